// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Status

This block recovers bytes from an asynchronous serial line. The line passes through a two-flop synchronizer and is sampled on an oversampling enable (`os_tick`, sixteen ticks per bit). A falling edge starts a character, but only if the line is still low half a bit later. Eight data bits are then taken at bit centres, least significant bit first. An optional parity bit follows, then one or two stop bits. Parity can be odd or even. In two-stop mode only the first stop bit is checked.

The finished character goes into a data register that a host reads through a small register port. Address 0 is the received byte. Address 1 is the status byte:

| Status bit | Meaning |
|---|---|
| 0 | data ready |
| 1 | framing error |
| 2 | parity error |
| 3 | overrun |
| 7:4 | read as zero |

The three error bits are sticky. The host clears one by reading the status byte while that bit shows 1, then writing a 0 to the same bit position. A pending framing or parity error stops the receiver from accepting new characters until the host clears it.

Top module: `serial_rx_status`

## Requirements
- R1: With `os_tick` high, a character of 8 data bits sent least significant bit first (start low, stop high) is loaded into the data register. Ready (status bit 0) is set when the first stop bit is sampled.
- R2: With `cfg_parity_en` high, a parity bit follows the last data bit. The 1s across the data and parity bits must total an odd number when `cfg_parity_odd` is 1, or an even number when it is 0. A mismatch sets the parity-error flag (status bit 2).
- R3: A first stop bit sampled as 0 sets the framing-error flag (status bit 1).
- R4: A character with a framing or parity error is still written into the data register, but ready is not set by it.
- R5: While the framing-error or parity-error flag is 1, a new character on the line is ignored entirely. The data register and all flags keep their values.
- R6: An error flag (status bits 1 to 3) clears only when 0 is written to its bit at address 1 after a status read showed it as 1. Writing 0 without such a read, or writing 1, leaves the flag set.
- R7: An error-free character that arrives while ready is 1 sets the overrun flag (status bit 3). The old byte stays in the data register and ready stays 1.
- R8: A host read of address 0 returns the data register on the next clock and clears ready.
- R9: In two-stop mode only the first stop bit is checked. A 0 in the second stop bit has no effect, and a 0 in the first stop bit still sets the framing-error flag.
- R10: While `rx_enable` is low, characters are not received, and both error flags keep their values.
- R11: A low pulse on the line that has ended by the half-bit point is treated as a false start. It changes nothing, and the next proper character is still received.
- R12: After reset every flag is 0 and `host_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, OS_RATE ticks per bit |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rx_enable | input | 1 | Receive enable |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_parity_en | input | 1 | 1 adds a parity bit |
| cfg_parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 1 | 0 selects the data register, 1 selects the status register |
| host_wdata | input | DATA_W | Write data; bits 1 to 3 act on the error flags |
| host_rdata | output | DATA_W | Registered read data |
| flag_ready | output | 1 | Data-ready flag |
| flag_frame_err | output | 1 | Framing-error flag |
| flag_parity_err | output | 1 | Parity-error flag |
| flag_overrun | output | 1 | Overrun flag |

## Verification
The timings below assume `os_tick` is high on every clock and count clock edges from the first edge after the start bit's falling edge reaches `rx_line`:

| Event | Edge |
|---|---|
| Start recognised | 3 |
| Start confirmed at half bit | 11 |
| Bit j of the character sampled | 11 + 16·j |
| Flags and data register updated for a stop bit at position j | 11 + 16·j + 1 |

Bit positions count from the start bit at 0. A stop bit therefore sits at position 9 without parity and at position 10 with parity.

The bench's behavioural model changes its expected flags one nanosecond after that edge. It compares all four flag outputs with the model at every falling clock edge. Register reads are due on the edge that ends the read strobe and are checked just after it. Each clear or arm step of the model takes effect at that same edge.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_STOP2
  } rx_state_e;

  // error flag indices inside the sticky vector; status bit = index + 1
  localparam int ERR_FRAME  = 0;
  localparam int ERR_PARITY = 1;
  localparam int ERR_OVER   = 2;
  localparam int ERR_N      = 3;

  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;

endpackage

// File: rtl/rx_sync.sv
`timescale 1ns/1ps
module rx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
`timescale 1ns/1ps
module rx_framer
  import serial_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              rxd,
  input  logic              enable,
  input  logic              block,
  input  logic              two_stop,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              done,
  output logic [DATA_W-1:0] dout,
  output logic              fer_o,
  output logic              per_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OS_RATE/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OS_RATE - 1);
  localparam logic [IDX_W-1:0] TOP  = IDX_W'(DATA_W - 1);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic              par_bad;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; cnt <= '0; idx <= '0; shreg <= '0;
      par_acc <= 1'b0; par_bad <= 1'b0; prev <= 1'b1;
      done <= 1'b0; dout <= '0; fer_o <= 1'b0; per_o <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) prev <= rxd;
      if (!enable) begin
        state <= ST_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        if (state != ST_IDLE) cnt <= cnt + 1'b1;
        unique case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (prev && !rxd && !block) state <= ST_START;
          end
          ST_START: if (cnt == MID) begin
            cnt     <= '0;
            idx     <= '0;
            par_acc <= 1'b0;
            par_bad <= 1'b0;
            state   <= rxd ? ST_IDLE : ST_DATA;
          end
          ST_DATA: if (cnt == LAST) begin
            shreg   <= {rxd, shreg[DATA_W-1:1]};
            par_acc <= par_acc ^ rxd;
            if (idx == TOP) state <= par_en ? ST_PAR : ST_STOP;
            else idx <= idx + 1'b1;
          end
          ST_PAR: if (cnt == LAST) begin
            par_bad <= ((par_acc ^ rxd) != par_odd);
            state   <= ST_STOP;
          end
          ST_STOP: if (cnt == LAST) begin
            done  <= 1'b1;
            dout  <= shreg;
            fer_o <= !rxd;
            per_o <= par_en && par_bad;
            state <= two_stop ? ST_STOP2 : ST_IDLE;
          end
          ST_STOP2: if (cnt == LAST) state <= ST_IDLE;
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done) else $error("done longer than one cycle"); // R1
  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && block) |=> state == ST_IDLE) else $error("start while error pending"); // R5
  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (rst) !enable |=> (state == ST_IDLE && !done)) else $error("active while disabled"); // R10
endmodule

// File: rtl/rx_status_regs.sv
`timescale 1ns/1ps
module rx_status_regs
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] din,
  input  logic              fer_in,
  input  logic              per_in,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready_o,
  output logic [ERR_N-1:0]  err_o
);
  localparam int STAT_W = ERR_N + 1;

  logic [DATA_W-1:0] data_q;
  logic              ready_q;
  logic [ERR_N-1:0]  err_q;
  logic [ERR_N-1:0]  arm_q;
  logic [ERR_N-1:0]  err_set;
  logic              bad_char;
  logic              rd_stat, wr_stat, rd_data_reg;
  logic [STAT_W-1:0] stat_vec;
  logic              unused_wbits;

  assign bad_char    = fer_in || per_in;
  assign rd_stat     = rd_en && (addr == ADDR_STAT);
  assign wr_stat     = wr_en && (addr == ADDR_STAT);
  assign rd_data_reg = rd_en && (addr == ADDR_DATA);
  assign stat_vec    = {err_q, ready_q};
  assign unused_wbits = ^{wr_data[DATA_W-1:STAT_W], wr_data[0]};

  always_comb begin
    err_set             = '0;
    err_set[ERR_FRAME]  = done && fer_in;
    err_set[ERR_PARITY] = done && per_in;
    err_set[ERR_OVER]   = done && !bad_char && ready_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      ready_q <= 1'b0;
      rd_data <= '0;
    end else begin
      if (rd_en) rd_data <= (addr == ADDR_STAT) ? DATA_W'(stat_vec) : data_q;
      if (rd_data_reg) ready_q <= 1'b0;
      if (done && (bad_char || !ready_q)) data_q <= din;
      if (done && !bad_char && !ready_q) ready_q <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < ERR_N; i++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst) begin
          err_q[i] <= 1'b0;
          arm_q[i] <= 1'b0;
        end else begin
          if (rd_stat && err_q[i]) arm_q[i] <= 1'b1;
          if (wr_stat && arm_q[i] && !wr_data[i+1]) begin
            err_q[i] <= 1'b0;
            arm_q[i] <= 1'b0;
          end
          if (err_set[i]) err_q[i] <= 1'b1;
        end
      end
    end
  endgenerate

  assign ready_o = ready_q;
  assign err_o   = err_q;

  AST_ERR_NO_READY: assert property (@(posedge clk) disable iff (rst) (done && bad_char && !ready_q) |=> !ready_q) else $error("ready set by bad char"); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst) (done && !bad_char && ready_q) |=> (data_q == $past(data_q) && err_q[ERR_OVER])) else $error("overrun lost data"); // R7
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst) (wr_stat && !arm_q[ERR_FRAME] && err_q[ERR_FRAME]) |=> err_q[ERR_FRAME]) else $error("flag cleared unarmed"); // R6
  AST_ARM_HAS_FLAG: assert property (@(posedge clk) disable iff (rst) (arm_q & ~err_q) == '0) else $error("arm without flag"); // R6
endmodule

// File: rtl/serial_rx_status.sv
`timescale 1ns/1ps
module serial_rx_status
  import serial_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              rx_line,
  input  logic              rx_enable,
  input  logic              cfg_two_stop,
  input  logic              cfg_parity_en,
  input  logic              cfg_parity_odd,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              flag_ready,
  output logic              flag_frame_err,
  output logic              flag_parity_err,
  output logic              flag_overrun
);
  logic              line_s;
  logic              chr_done, chr_fer, chr_per;
  logic [DATA_W-1:0] chr_data;
  logic [ERR_N-1:0]  err;

  rx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(rx_line), .q(line_s)
  );

  rx_framer #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_framer (
    .clk(clk), .rst(rst), .tick(os_tick), .rxd(line_s), .enable(rx_enable),
    .block(err[ERR_FRAME] || err[ERR_PARITY]),
    .two_stop(cfg_two_stop), .par_en(cfg_parity_en), .par_odd(cfg_parity_odd),
    .done(chr_done), .dout(chr_data), .fer_o(chr_fer), .per_o(chr_per)
  );

  rx_status_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .done(chr_done), .din(chr_data),
    .fer_in(chr_fer), .per_in(chr_per),
    .rd_en(host_rd), .wr_en(host_wr), .addr(host_addr), .wr_data(host_wdata),
    .rd_data(host_rdata), .ready_o(flag_ready), .err_o(err)
  );

  assign flag_frame_err  = err[ERR_FRAME];
  assign flag_parity_err = err[ERR_PARITY];
  assign flag_overrun    = err[ERR_OVER];
endmodule

// File: tb/serial_rx_status_test.sv
`timescale 1ns/1ps
module serial_rx_status_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b1;
  logic       rx_line = 1'b1;
  logic       rx_enable = 1'b1;
  logic       cfg_two_stop = 1'b0;
  logic       cfg_parity_en = 1'b0;
  logic       cfg_parity_odd = 1'b0;
  logic       host_rd = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       flag_ready, flag_frame_err, flag_parity_err, flag_overrun;

  int n_checks = 0;
  int n_fail   = 0;
  bit mon_on   = 1'b0;

  // behavioural model: err[0]=frame, err[1]=parity, err[2]=overrun
  bit       m_ready = 1'b0;
  bit [2:0] m_err   = 3'b000;
  bit [2:0] m_arm   = 3'b000;
  bit [7:0] m_data  = 8'h00;

  always #5 clk = ~clk;

  serial_rx_status uut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .rx_line(rx_line), .rx_enable(rx_enable),
    .cfg_two_stop(cfg_two_stop), .cfg_parity_en(cfg_parity_en), .cfg_parity_odd(cfg_parity_odd),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .flag_ready(flag_ready), .flag_frame_err(flag_frame_err),
    .flag_parity_err(flag_parity_err), .flag_overrun(flag_overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on)
      check("R1 R2 R3 R4 R7 R8 flag compare",
            {28'd0, flag_overrun, flag_parity_err, flag_frame_err, flag_ready},
            {28'd0, m_err, m_ready});
  end

  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit stop1, input bit stop2);
    bit take;
    bit pbit;
    bit fe, pe;
    take = rx_enable && !m_err[0] && !m_err[1];
    pbit = (^d) ^ cfg_parity_odd ^ bad_par;
    @(posedge clk); #1 rx_line = 1'b0;
    repeat (16) @(posedge clk);
    for (int k = 0; k < 8; k++) begin
      #1 rx_line = d[k];
      repeat (16) @(posedge clk);
    end
    if (cfg_parity_en) begin
      #1 rx_line = pbit;
      repeat (16) @(posedge clk);
    end
    #1 rx_line = stop1;
    repeat (12) @(posedge clk);
    #1;
    if (take) begin
      fe = !stop1;
      pe = cfg_parity_en && bad_par;
      if (fe || pe) begin
        m_data = d;
        m_err[0] = m_err[0] | fe;
        m_err[1] = m_err[1] | pe;
      end else if (m_ready) m_err[2] = 1'b1;
      else begin
        m_data  = d;
        m_ready = 1'b1;
      end
    end
    repeat (4) @(posedge clk);
    if (cfg_two_stop) begin
      #1 rx_line = stop2;
      repeat (16) @(posedge clk);
    end
    #1 rx_line = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  task automatic host_read(input bit a, input string req);
    logic [7:0] exp;
    exp = a ? {4'h0, m_err, m_ready} : m_data;
    @(posedge clk); #1 host_rd = 1'b1; host_addr = a;
    @(posedge clk); #1 host_rd = 1'b0;
    if (a) m_arm = m_arm | m_err;
    else m_ready = 1'b0;
    check(req, {24'd0, host_rdata}, {24'd0, exp});
  endtask

  task automatic host_write(input bit a, input logic [7:0] v);
    @(posedge clk); #1 host_wr = 1'b1; host_addr = a; host_wdata = v;
    @(posedge clk); #1 host_wr = 1'b0;
    if (a) begin
      for (int i = 0; i < 3; i++) begin
        if (m_arm[i] && !v[i+1]) begin
          m_err[i] = 1'b0;
          m_arm[i] = 1'b0;
        end
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R12 reset flags", {flag_overrun, flag_parity_err, flag_frame_err, flag_ready}, 4'h0);
    check("R12 reset rdata", host_rdata, 8'h00);
    mon_on = 1'b1;

    // plain 8N1 character
    send_frame(8'hA5, 1'b0, 1'b1, 1'b1);
    check("R1 ready after char", flag_ready, 1'b1);
    host_read(1'b0, "R1 R8 data read");
    @(negedge clk);
    check("R8 ready cleared by read", flag_ready, 1'b0);

    // even then odd parity, correct
    cfg_parity_en = 1'b1; cfg_parity_odd = 1'b0;
    send_frame(8'h3C, 1'b0, 1'b1, 1'b1);
    host_read(1'b0, "R2 even parity data");
    cfg_parity_odd = 1'b1;
    send_frame(8'h81, 1'b0, 1'b1, 1'b1);
    host_read(1'b0, "R2 odd parity data");

    // bad parity
    send_frame(8'h5A, 1'b1, 1'b1, 1'b1);
    check("R2 parity flag", flag_parity_err, 1'b1);
    check("R4 no ready on error", flag_ready, 1'b0);
    host_read(1'b0, "R4 errored byte loaded");

    // blocked while parity error pending
    send_frame(8'h11, 1'b0, 1'b1, 1'b1);
    host_read(1'b0, "R5 blocked char dropped");
    check("R5 ready stays low", flag_ready, 1'b0);

    // clear rules
    host_write(1'b1, 8'h00);
    @(negedge clk);
    check("R6 write without read ignored", flag_parity_err, 1'b1);
    host_read(1'b1, "R6 status shows parity");
    host_write(1'b1, 8'hFF);
    @(negedge clk);
    check("R6 write one ignored", flag_parity_err, 1'b1);
    host_write(1'b1, 8'h00);
    @(negedge clk);
    check("R6 armed clear", flag_parity_err, 1'b0);

    // framing error
    cfg_parity_en = 1'b0;
    send_frame(8'h77, 1'b0, 1'b0, 1'b1);
    check("R3 framing flag", flag_frame_err, 1'b1);
    host_read(1'b0, "R4 framed byte loaded");
    rx_enable = 1'b0;
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R10 disable keeps framing flag", flag_frame_err, 1'b1);
    rx_enable = 1'b1;
    host_read(1'b1, "R3 status shows framing");
    host_write(1'b1, 8'h00);
    @(negedge clk);
    check("R6 framing cleared", flag_frame_err, 1'b0);

    // overrun
    send_frame(8'h12, 1'b0, 1'b1, 1'b1);
    send_frame(8'h34, 1'b0, 1'b1, 1'b1);
    check("R7 overrun flag", flag_overrun, 1'b1);
    check("R7 ready kept", flag_ready, 1'b1);
    host_read(1'b0, "R7 old byte kept");
    host_read(1'b1, "R7 status overrun");
    host_write(1'b1, 8'h00);
    @(negedge clk);
    check("R6 overrun cleared", flag_overrun, 1'b0);

    // two stop bits
    cfg_two_stop = 1'b1;
    send_frame(8'h9C, 1'b0, 1'b1, 1'b0);
    check("R9 second stop ignored", flag_frame_err, 1'b0);
    host_read(1'b0, "R9 two-stop data");
    send_frame(8'hC3, 1'b0, 1'b0, 1'b1);
    check("R9 first stop checked", flag_frame_err, 1'b1);
    host_read(1'b1, "R9 status");
    host_write(1'b1, 8'h00);
    cfg_two_stop = 1'b0;

    // receive disabled
    rx_enable = 1'b0;
    send_frame(8'h44, 1'b0, 1'b1, 1'b1);
    check("R10 no char while disabled", flag_ready, 1'b0);
    host_read(1'b0, "R10 data unchanged");
    rx_enable = 1'b1;
    repeat (4) @(posedge clk);

    // false start
    @(posedge clk); #1 rx_line = 1'b0;
    repeat (4) @(posedge clk);
    #1 rx_line = 1'b1;
    repeat (40) @(posedge clk);
    @(negedge clk);
    check("R11 false start ignored", {flag_frame_err, flag_ready}, 2'b00);
    send_frame(8'h66, 1'b0, 1'b1, 1'b1);
    host_read(1'b0, "R11 next char received");

    repeat (5) @(posedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule